// File: doc/BRIEF.md
# Speculative Instruction Prefetch Queue

This block sits between instruction fetch and the execution units of a pipelined core. The fetch side delivers instruction words, each with its own address. The queue holds them in arrival order, and execution takes them only from the head. Fetch may follow a conditional branch that was predicted taken, so the queue can fill with words from the branch target before the branch resolves.

When such a branch resolves as not taken, the target-path words in the queue are wrong. The queue discards all of them and raises a one-cycle status strobe marking a cancelled branch, with the exact number of entries dropped. It also pulses a fetch redirect carrying the fall-through address, which is the branch address plus 4. When an instruction that has already left the head faults, every queued entry is younger than it. The queue discards them all and reports an exception flush with its count, and it does not redirect fetch.

Because the branch or the faulting instruction has always left the queue before it resolves, either flush empties the whole queue.

Top module: `spec_prefetch_queue`

## Requirements
- R1: After synchronous reset the queue is empty. `issue_valid`, `flush_valid` and `redirect_valid` are low, `fetch_ready` is high, and `flush_code` and `flush_count` are 0.
- R2: Entries leave through `issue_instr`/`issue_addr` in the order they were accepted, with instruction and address unchanged. An entry is accepted on a clock edge where `fetch_valid && fetch_ready`. It leaves on a clock edge where `issue_valid && issue_ready`.
- R3: With 4 entries held, `fetch_ready` is low and a word offered on `fetch_valid` is ignored. The queue never holds more than 4 entries.
- R4: When `mispredict` is high on an edge and `exception` is low, the cycle after has `flush_valid` high for one cycle. In that cycle `flush_code` is 2'b01 and `flush_count` equals the number of entries held before that edge.
- R5: When `mispredict` is high on an edge and `exception` is low, the cycle after has `redirect_valid` high for one cycle. In that cycle `redirect_addr` equals `branch_addr` + 4.
- R6: When `exception` is high on an edge, the cycle after has `flush_valid` high with `flush_code` 2'b10 and `flush_count` equal to the number of entries held before that edge. `redirect_valid` stays low.
- R7: A flush takes priority over an accept and an issue on the same edge. Both are ignored, and the queue is empty in the following cycle.
- R8: When `mispredict` and `exception` are high on the same edge, the exception wins. The code is 2'b10 and there is no redirect.
- R9: Whenever `flush_valid` is low, `flush_code` is 2'b00 and `flush_count` is 0.
- R10: An accept and an issue on the same edge leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch offers a word |
| fetch_instr | input | 32 | Offered instruction word |
| fetch_addr | input | 32 | Address of the offered word |
| fetch_ready | output | 1 | Queue has room |
| issue_ready | input | 1 | Execution takes the head entry |
| issue_valid | output | 1 | Head entry present |
| issue_instr | output | 32 | Head instruction |
| issue_addr | output | 32 | Head address |
| mispredict | input | 1 | Predicted-taken branch resolved not taken |
| branch_addr | input | 32 | Address of the mispredicted branch |
| exception | input | 1 | An issued instruction faulted |
| flush_valid | output | 1 | One-cycle flush status strobe |
| flush_code | output | 2 | 00 none, 01 branch cancel, 10 exception flush |
| flush_count | output | 3 | Number of entries discarded |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_addr | output | 32 | Fetch restart address |

## Verification
An accepted word becomes visible at the head in the cycle after the accepting edge. An issue removes the head, and the next entry shows in the cycle after the issuing edge. Flush status and redirect are registered, so they appear in the one cycle after the edge that saw `mispredict` or `exception`. The bench drives inputs on the falling edge and keeps a reference queue that it advances with the same inputs. It compares every output at the next falling edge, so each comparison falls exactly one rising edge after its stimulus.

// File: rtl/spq_pkg.sv
package spq_pkg;
  typedef enum logic [1:0] {
    FL_NONE   = 2'b00,
    FL_BRANCH = 2'b01,
    FL_EXCEPT = 2'b10
  } flush_code_e;
endpackage

// File: rtl/spq_store.sv
// Entry storage: single write port, asynchronous read of the head slot.
module spq_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ptr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/spq_ptrs.sv
// Head/tail pointers and occupancy; a flush overrides push and pop.
module spq_ptrs #(
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  output logic          push_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  logic pop_ok;

  assign full    = (occ == CW'(DEPTH));
  assign empty   = (occ == '0);
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
  p_empty_after_flush_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0));
  p_count_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> (occ == $past(occ)));
endmodule

// File: rtl/spq_report.sv
// Registered flush status and fetch redirect.
module spq_report
  import spq_pkg::*;
#(
  parameter int AW_BUS      = 32,
  parameter int CW          = 3,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mispredict,
  input  logic              exception,
  input  logic [AW_BUS-1:0] branch_addr,
  input  logic [CW-1:0]     occ,
  output logic              flush_valid,
  output flush_code_e       flush_code,
  output logic [CW-1:0]     flush_count,
  output logic              redirect_valid,
  output logic [AW_BUS-1:0] redirect_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flush_valid    <= 1'b0;
      flush_code     <= FL_NONE;
      flush_count    <= '0;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
    end else begin
      flush_valid    <= mispredict || exception;
      flush_code     <= exception ? FL_EXCEPT : (mispredict ? FL_BRANCH : FL_NONE);
      flush_count    <= (mispredict || exception) ? occ : '0;
      redirect_valid <= mispredict && !exception;
      if (mispredict && !exception)
        redirect_addr <= branch_addr + AW_BUS'(INSTR_BYTES);
    end
  end

  p_idle_fields_r9: assert property (@(posedge clk) disable iff (rst)
    !flush_valid |-> (flush_code == FL_NONE && flush_count == '0));
  p_redirect_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (mispredict && !exception) |=> (redirect_valid && redirect_addr == $past(branch_addr) + AW_BUS'(INSTR_BYTES)));
  p_exc_no_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    exception |=> (!redirect_valid && flush_code == FL_EXCEPT));
  p_branch_code_r4: assert property (@(posedge clk) disable iff (rst)
    (mispredict && !exception) |=> (flush_code == FL_BRANCH && flush_count == $past(occ)));
endmodule

// File: rtl/spec_prefetch_queue.sv
module spec_prefetch_queue
  import spq_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int IW          = 32,
  parameter int AW_BUS      = 32,
  parameter int INSTR_BYTES = 4,
  localparam int PW         = $clog2(DEPTH),
  localparam int CW         = $clog2(DEPTH + 1),
  localparam int DW         = IW + AW_BUS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [IW-1:0]     fetch_instr,
  input  logic [AW_BUS-1:0] fetch_addr,
  output logic              fetch_ready,
  input  logic              issue_ready,
  output logic              issue_valid,
  output logic [IW-1:0]     issue_instr,
  output logic [AW_BUS-1:0] issue_addr,
  input  logic              mispredict,
  input  logic [AW_BUS-1:0] branch_addr,
  input  logic              exception,
  output logic              flush_valid,
  output logic [1:0]        flush_code,
  output logic [CW-1:0]     flush_count,
  output logic              redirect_valid,
  output logic [AW_BUS-1:0] redirect_addr
);
  logic          flush;
  logic          push_ok;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] occ;
  logic          full;
  logic          empty;
  logic [DW-1:0] head;
  flush_code_e   code_q;

  assign flush = mispredict || exception;

  spq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_req(fetch_valid), .pop_req(issue_ready),
    .flush(flush), .push_ok(push_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .occ(occ), .full(full), .empty(empty)
  );

  spq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .wr_en(push_ok), .wr_ptr(wr_ptr),
    .wr_data({fetch_instr, fetch_addr}), .rd_ptr(rd_ptr), .rd_data(head)
  );

  spq_report #(.AW_BUS(AW_BUS), .CW(CW), .INSTR_BYTES(INSTR_BYTES)) u_report (
    .clk(clk), .rst(rst), .mispredict(mispredict), .exception(exception),
    .branch_addr(branch_addr), .occ(occ), .flush_valid(flush_valid),
    .flush_code(code_q), .flush_count(flush_count),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
  );

  assign flush_code  = code_q;
  assign fetch_ready = !full;
  assign issue_valid = !empty;
  assign issue_instr = head[DW-1:AW_BUS];
  assign issue_addr  = head[AW_BUS-1:0];

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    !fetch_ready |-> issue_valid);
  p_flush_drains_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!issue_valid && fetch_ready));
endmodule

// File: tb/spec_prefetch_queue_tb.sv
`timescale 1ns/1ps
module spec_prefetch_queue_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid;
  logic [31:0] fetch_instr;
  logic [31:0] fetch_addr;
  logic        fetch_ready;
  logic        issue_ready;
  logic        issue_valid;
  logic [31:0] issue_instr;
  logic [31:0] issue_addr;
  logic        mispredict;
  logic [31:0] branch_addr;
  logic        exception;
  logic        flush_valid;
  logic [1:0]  flush_code;
  logic [2:0]  flush_count;
  logic        redirect_valid;
  logic [31:0] redirect_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] m_instr [4];
  logic [31:0] m_addr  [4];
  int          m_cnt;
  logic        e_fv, e_rv;
  logic [1:0]  e_code;
  logic [2:0]  e_cnt;
  logic [31:0] e_raddr;

  always #2.5 clk = ~clk;

  spec_prefetch_queue u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
    .fetch_addr(fetch_addr), .fetch_ready(fetch_ready), .issue_ready(issue_ready),
    .issue_valid(issue_valid), .issue_instr(issue_instr), .issue_addr(issue_addr),
    .mispredict(mispredict), .branch_addr(branch_addr), .exception(exception),
    .flush_valid(flush_valid), .flush_code(flush_code), .flush_count(flush_count),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_code(input bit mis, input bit exc);
    return exc ? 2'b10 : (mis ? 2'b01 : 2'b00);
  endfunction

  task automatic check_all();
    chk(fetch_ready == (m_cnt < 4), "R3 fetch_ready", 64'(fetch_ready), 64'(m_cnt < 4));
    chk(issue_valid == (m_cnt > 0), "R2 issue_valid", 64'(issue_valid), 64'(m_cnt > 0));
    if (m_cnt > 0) begin
      chk(issue_instr == m_instr[0], "R2 issue_instr", 64'(issue_instr), 64'(m_instr[0]));
      chk(issue_addr == m_addr[0], "R2 issue_addr", 64'(issue_addr), 64'(m_addr[0]));
    end
    chk(flush_valid == e_fv, "R4/R6 flush_valid", 64'(flush_valid), 64'(e_fv));
    chk(flush_code == e_code, "R8 R9 flush_code", 64'(flush_code), 64'(e_code));
    chk(flush_count == e_cnt, "R4 R6 R9 flush_count", 64'(flush_count), 64'(e_cnt));
    chk(redirect_valid == e_rv, "R5 redirect_valid", 64'(redirect_valid), 64'(e_rv));
    if (e_rv)
      chk(redirect_addr == e_raddr, "R5 redirect_addr", 64'(redirect_addr), 64'(e_raddr));
  endtask

  // Called at a falling edge: drive, advance reference, check at next falling edge.
  task automatic step(input bit fv, input logic [31:0] fi, input logic [31:0] fa,
                      input bit ir, input bit mis, input bit exc, input logic [31:0] ba);
    bit push, pop;
    fetch_valid = fv; fetch_instr = fi; fetch_addr = fa;
    issue_ready = ir; mispredict = mis; exception = exc; branch_addr = ba;
    e_fv = mis || exc;
    e_code = exp_code(mis, exc);
    e_cnt = (mis || exc) ? 3'(m_cnt) : 3'd0;
    e_rv = mis && !exc;
    if (e_rv) e_raddr = ba + 32'd4;
    if (mis || exc) begin
      m_cnt = 0;                                  // R7
    end else begin
      push = fv && (m_cnt < 4);
      pop  = ir && (m_cnt > 0);
      if (pop) begin
        for (int i = 0; i < 3; i++) begin
          m_instr[i] = m_instr[i+1];
          m_addr[i]  = m_addr[i+1];
        end
        m_cnt--;
      end
      if (push) begin
        m_instr[m_cnt] = fi;
        m_addr[m_cnt]  = fa;
        m_cnt++;
      end
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; fetch_valid = 0; fetch_instr = 0; fetch_addr = 0;
    issue_ready = 0; mispredict = 0; exception = 0; branch_addr = 0;
    m_cnt = 0; e_fv = 0; e_rv = 0; e_code = 0; e_cnt = 0; e_raddr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_all();
    chk(flush_code == 2'b00 && flush_count == 3'd0, "R1 reset status", 64'({flush_code, flush_count}), 64'd0);

    // R3: fill to 4, then offer a fifth word
    for (int i = 0; i < 4; i++) step(1, 32'hA000_0000 + i, 32'h100 + 4*i, 0, 0, 0, 0);
    step(1, 32'hDEAD_BEEF, 32'h999, 0, 0, 0, 0);
    // R2 R3: drain shows only the four accepted words
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0);

    // R10: simultaneous accept and issue
    step(1, 32'h1, 32'h200, 0, 0, 0, 0);
    step(1, 32'h2, 32'h204, 1, 0, 0, 0);
    step(1, 32'h3, 32'h208, 1, 0, 0, 0);
    // R4 R5 R7: mispredict with a push and issue in the same cycle
    step(1, 32'h4, 32'h20C, 1, 1, 0, 32'h0000_1FFC);
    step(0, 0, 0, 0, 0, 0, 0);

    // R6: exception at full
    for (int i = 0; i < 4; i++) step(1, 32'hB0 + i, 32'h300 + 4*i, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 32'h55);
    // R8: both at once, queue holding 2
    step(1, 32'hC1, 32'h400, 0, 0, 0, 0);
    step(1, 32'hC2, 32'h404, 0, 0, 0, 0);
    step(1, 32'hC3, 32'h408, 1, 1, 1, 32'h77);
    // back-to-back flushes on an empty queue (count 0)
    step(0, 0, 0, 0, 1, 0, 32'hFFFF_FFFC);
    step(0, 0, 0, 0, 0, 0, 0);

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      bit mis, exc;
      r = int'($urandom_range(99));
      mis = (r < 4);
      exc = (r >= 96);
      step(($urandom_range(99) < 60), $urandom, $urandom & 32'hFFFF_FFFC,
           ($urandom_range(99) < 45), mis, exc, $urandom & 32'hFFFF_FFFC);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule